// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is one 16-pin general-purpose I/O bank on a simple synchronous register bus. Each pin has a direction bit. An output pin drives the value held in an output register. Software can write that register directly, or it can use two write-one aliases that only raise bits or only lower bits. Because those aliases touch no other bit, separate software tasks can change their own pins without a read-modify-write sequence.

Pin levels pass through a two-flop synchronizer. The synchronized value is readable and also feeds a per-pin edge detector. Each pin can be armed for rising edges, falling edges or both. A detected edge latches a status bit, and software clears that bit by writing 1 to it. The OR of all status bits drives a level bank interrupt. A one-cycle event pulse marks each 0-to-1 transition of that interrupt, for use as a DMA request.

The bus has a one-cycle read latency. A write takes effect at the clock edge on which it is presented.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held, and until the first bus write after reset, `pin_oe`, `pin_out`, `bank_irq` and `bank_evt` are 0, and the status and both edge-enable registers read 0.
- R2: The direction register at offset 0 is read/write. Bit n = 1 makes pin n an output, so `pin_oe[n]` = 1 from the write edge on.
- R3: A write to the set alias at offset 2 forces to 1 every output bit whose data bit is 1. Output bits written as 0 keep their value.
- R4: A write to the clear alias at offset 3 forces to 0 every output bit whose data bit is 1. Output bits written as 0 keep their value.
- R5: A write to the output register at offset 1 replaces all 16 bits. A read at offset 1 returns the driven value, not the pin level. `pin_out` always equals this register.
- R6: A read at offset 4 returns the pin levels after the two-flop synchronizer. Writes to offset 4 are ignored.
- R7: The rising-enable register is at offset 5 and the falling-enable register at offset 6.
  - A synchronized 0-to-1 change on a pin whose rising enable is set latches status bit n.
  - A 1-to-0 change on a pin whose falling enable is set does the same.
  - Edges on pins whose matching enable is clear are ignored.
  - The status bit is set at the third clock edge after the pin changes.
- R8: The status register is at offset 7, and writing 1 to a bit clears it. A bit written 0 is unchanged. If an edge on the pin is latched at the same edge as the clear write, the bit stays set.
- R9: `bank_irq` is a level equal to the OR of the 16 status bits. It stays high until every status bit is cleared.
- R10: `bank_evt` is high for exactly one cycle, in the cycle after `bank_irq` goes from 0 to 1. It does not pulse again while `bank_irq` stays high.
- R11: A read request presented at a clock edge puts its data on `bus_rdata` after that edge. The value is held until the next read. Reads of the set and clear aliases return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output drive values |
| pin_oe | output | 16 | Output enables (1 = drive) |
| bank_irq | output | 1 | Level bank interrupt |
| bank_evt | output | 1 | One-cycle event request |

## Verification
Each result has a fixed latency, counted in clock edges:
- Register writes and `pin_out`/`pin_oe` change at the write edge.
- Read data appears one edge after the request.
- A pin change reaches the input register after two edges and the status bit and `bank_irq` after three.
- `bank_evt` is high only in the cycle after the third edge.

The bench drives every input on the falling clock edge and samples on a later falling edge. It counts those exact edges before each check, so a result one cycle early or late fails. The clear-versus-edge collision is placed deliberately: the clear write is timed to land on the third edge after the pin change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 3;

  // Register offsets on the bank bus
  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_SET  = 3'd2,
    REG_CLR  = 3'd3,
    REG_IN   = 3'd4,
    REG_RISE = 3'd5,
    REG_FALL = 3'd6,
    REG_STAT = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N_PINS = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] d,
  output logic [N_PINS-1:0] q
);

  logic [N_PINS-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N_PINS-1:0] stg_d;

    if (s == 0) begin : g_first
      always_comb stg_d = d;
    end else begin : g_next
      always_comb stg_d = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat #(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] smp,
  input  logic [N_PINS-1:0] rise_en,
  input  logic [N_PINS-1:0] fall_en,
  input  logic              clr_we,
  input  logic [N_PINS-1:0] clr_mask,
  output logic [N_PINS-1:0] stat,
  output logic              irq,
  output logic              evt
);

  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] stat_q;
  logic [N_PINS-1:0] stat_d;
  logic [N_PINS-1:0] hit;
  logic [N_PINS-1:0] clr_eff;
  logic              irq_q;
  logic              irq_now;

  // Edge qualification: compare the current sample with the one from the previous cycle
  always_comb begin
    hit     = (smp & ~prev_q & rise_en) | (~smp & prev_q & fall_en);
    clr_eff = clr_we ? clr_mask : '0;
    // A new edge takes priority over a clear in the same cycle
    stat_d  = (stat_q & ~clr_eff) | hit;
    irq_now = |stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= smp;
      stat_q <= stat_d;
      irq_q  <= irq_now;
    end
  end

  assign stat = stat_q;
  assign irq  = irq_now;
  assign evt  = irq_now & ~irq_q;

  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((stat_q & $past(hit)) == $past(hit)));                         // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((stat_q & $past(clr_mask & ~hit)) == '0));                     // R8
  AST_IRQ_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_we) |=> irq);                                                 // R9
  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);                                                             // R10

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic [N_PINS-1:0] smp_in,
  input  logic [N_PINS-1:0] stat,
  output logic [N_PINS-1:0] bus_rdata,
  output logic [N_PINS-1:0] dir,
  output logic [N_PINS-1:0] out,
  output logic [N_PINS-1:0] rise_en,
  output logic [N_PINS-1:0] fall_en,
  output logic              stat_clr_we,
  output logic [N_PINS-1:0] stat_clr_mask
);

  reg_sel_e          sel;
  logic              wr;
  logic              rd;

  logic [N_PINS-1:0] dir_q,   dir_d;
  logic [N_PINS-1:0] out_q,   out_d;
  logic [N_PINS-1:0] rise_q,  rise_d;
  logic [N_PINS-1:0] fall_q,  fall_d;
  logic [N_PINS-1:0] rdata_q, rdata_d;
  logic [N_PINS-1:0] set_m,   clr_m;

  always_comb begin
    sel = reg_sel_e'(bus_addr);
    wr  = bus_en &  bus_we;
    rd  = bus_en & ~bus_we;
  end

  // Next-state logic for the writable registers
  always_comb begin
    dir_d       = dir_q;
    out_d       = out_q;
    rise_d      = rise_q;
    fall_d      = fall_q;
    set_m       = '0;
    clr_m       = '0;
    stat_clr_we = 1'b0;
    if (wr) begin
      case (sel)
        REG_DIR:  dir_d       = bus_wdata;
        REG_OUT:  out_d       = bus_wdata;
        REG_SET:  set_m       = bus_wdata;
        REG_CLR:  clr_m       = bus_wdata;
        REG_RISE: rise_d      = bus_wdata;
        REG_FALL: fall_d      = bus_wdata;
        REG_STAT: stat_clr_we = 1'b1;
        default:  ;
      endcase
    end
    // Set applied last so it wins over clear on a shared bit
    out_d = (out_d & ~clr_m) | set_m;
  end

  // Read mux, captured only on a read request
  always_comb begin
    rdata_d = rdata_q;
    if (rd) begin
      case (sel)
        REG_DIR:  rdata_d = dir_q;
        REG_OUT:  rdata_d = out_q;
        REG_IN:   rdata_d = smp_in;
        REG_RISE: rdata_d = rise_q;
        REG_FALL: rdata_d = fall_q;
        REG_STAT: rdata_d = stat;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata     = rdata_q;
  assign dir           = dir_q;
  assign out           = out_q;
  assign rise_en       = rise_q;
  assign fall_en       = fall_q;
  assign stat_clr_mask = bus_wdata;

  AST_SET_BITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_SET) |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));   // R3
  AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_SET) |=> ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))); // R3
  AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_CLR) |=> ((out_q & $past(bus_wdata)) == '0));                // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q));                                                     // R11

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              bank_irq,
  output logic              bank_evt
);

  logic              rst_n_int;
  logic [N_PINS-1:0] smp;
  logic [N_PINS-1:0] stat;
  logic [N_PINS-1:0] rise_en;
  logic [N_PINS-1:0] fall_en;
  logic              stat_clr_we;
  logic [N_PINS-1:0] stat_clr_mask;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (pin_in),
    .q     (smp)
  );

  gpio_regfile #(.N_PINS(N_PINS)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .bus_en        (bus_en),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .smp_in        (smp),
    .stat          (stat),
    .bus_rdata     (bus_rdata),
    .dir           (pin_oe),
    .out           (pin_out),
    .rise_en       (rise_en),
    .fall_en       (fall_en),
    .stat_clr_we   (stat_clr_we),
    .stat_clr_mask (stat_clr_mask)
  );

  gpio_edge_stat #(.N_PINS(N_PINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .smp      (smp),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .clr_we   (stat_clr_we),
    .clr_mask (stat_clr_mask),
    .stat     (stat),
    .irq      (bank_irq),
    .evt      (bank_evt)
  );

  AST_EVT_ON_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(bank_irq) |-> bank_evt);                                            // R10
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(bank_irq) |-> ($past(stat) == '0));                                 // R9

  always_comb begin
    if (!rst_n_int) begin
      AST_RESET_QUIET: assert (!bank_evt && pin_oe == '0 && pin_out == '0);  // R1
    end
  end

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

  logic        clk;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        bank_irq;
  logic        bank_evt;

  int n_run  = 0;
  int n_fail = 0;

  gpio_bank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .bank_irq  (bank_irq),
    .bank_evt  (bank_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [2:0] A_DIR = 3'd0, A_OUT = 3'd1, A_SET = 3'd2, A_CLR = 3'd3,
                         A_IN  = 3'd4, A_RISE = 3'd5, A_FALL = 3'd6, A_STAT = 3'd7;

  // {op(1=read-check), addr, wdata, expected}
  localparam int NV = 18;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, A_DIR,  16'h00FF, 16'h0000},  // R2
    {1'b1, A_DIR,  16'h0000, 16'h00FF},  // R2
    {1'b0, A_OUT,  16'h1234, 16'h0000},  // R5
    {1'b1, A_OUT,  16'h0000, 16'h1234},  // R5
    {1'b0, A_SET,  16'h8001, 16'h0000},  // R3
    {1'b1, A_OUT,  16'h0000, 16'h9235},  // R3
    {1'b0, A_CLR,  16'h1200, 16'h0000},  // R4
    {1'b1, A_OUT,  16'h0000, 16'h8035},  // R4
    {1'b0, A_SET,  16'h0000, 16'h0000},  // R3 zeros keep
    {1'b0, A_CLR,  16'h0000, 16'h0000},  // R4 zeros keep
    {1'b1, A_OUT,  16'h0000, 16'h8035},  // R3 R4
    {1'b1, A_SET,  16'h0000, 16'h0000},  // R11 alias reads 0
    {1'b1, A_CLR,  16'h0000, 16'h0000},  // R11 alias reads 0
    {1'b0, A_IN,   16'hAAAA, 16'h0000},  // R6 write ignored
    {1'b1, A_IN,   16'h0000, 16'h0000},  // R6
    {1'b0, A_OUT,  16'hFFFF, 16'h0000},  // R5
    {1'b1, A_OUT,  16'h0000, 16'hFFFF},  // R5
    {1'b1, A_STAT, 16'h0000, 16'h0000}   // R8
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    check("R1 pin_oe in reset", pin_oe, 16'h0);
    check("R1 irq/evt in reset", {14'h0, bank_irq, bank_evt}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pin_out after reset", pin_out, 16'h0);
    rd(A_STAT, r); check("R1 status reset", r, 16'h0);
    rd(A_RISE, r); check("R1 rise enable reset", r, 16'h0);
    rd(A_FALL, r); check("R1 fall enable reset", r, 16'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        rd(VEC[i][34:32], r);
        check($sformatf("vector %0d read", i), r, VEC[i][15:0]);
      end else begin
        wr(VEC[i][34:32], VEC[i][31:16]);
      end
    end
    check("R2 pin_oe follows direction", pin_oe, 16'h00FF);
    check("R5 pin_out follows output reg", pin_out, 16'hFFFF);
    repeat (2) @(negedge clk);
    check("R11 rdata held without read", bus_rdata, 16'h0000);

    // Edge detection: bit0 rising, bit1 falling, bit2 both
    wr(A_RISE, 16'h0005);
    wr(A_FALL, 16'h0006);
    pin_in = 16'h0007;
    repeat (2) @(negedge clk);
    check("R7 no status before third edge", {15'h0, bank_irq}, 16'h0);
    @(negedge clk);
    check("R9 irq after third edge", {15'h0, bank_irq}, 16'h1);
    check("R10 event pulse", {15'h0, bank_evt}, 16'h1);
    @(negedge clk);
    check("R10 event one cycle", {15'h0, bank_evt}, 16'h0);
    rd(A_STAT, r); check("R7 rising edges latched", r, 16'h0005);

    pin_in = 16'h0000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 no repeat pulse while irq high", {15'h0, bank_evt}, 16'h0);
    end
    check("R9 irq level held", {15'h0, bank_irq}, 16'h1);
    rd(A_STAT, r); check("R7 falling edges latched", r, 16'h0007);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, r); check("R8 partial clear", r, 16'h0005);
    check("R9 irq stays with bits left", {15'h0, bank_irq}, 16'h1);
    wr(A_STAT, 16'h0005);
    check("R9 irq drops when all clear", {15'h0, bank_irq}, 16'h0);

    // Output reads driven value, input reads pin level
    wr(A_DIR, 16'hFFFF);
    wr(A_OUT, 16'h00F0);
    pin_in = 16'h0F00;
    repeat (2) @(negedge clk);
    rd(A_IN, r); check("R6 synchronized input", r, 16'h0F00);
    rd(A_OUT, r); check("R5 output reads drive not pin", r, 16'h00F0);
    check("R5 pin_out port", pin_out, 16'h00F0);
    repeat (2) @(negedge clk);
    check("R7 disabled edges ignored", {15'h0, bank_irq}, 16'h0);
    rd(A_STAT, r); check("R7 status untouched by disabled pins", r, 16'h0000);

    // Clear colliding with a new edge
    pin_in = 16'h0001;
    repeat (4) @(negedge clk);
    rd(A_STAT, r); check("R7 bit0 rise", r, 16'h0001);
    pin_in = 16'h0005;
    repeat (2) @(negedge clk);
    wr(A_STAT, 16'h0005);
    check("R8 collision keeps irq", {15'h0, bank_irq}, 16'h1);
    check("R10 no pulse on collision", {15'h0, bank_evt}, 16'h0);
    rd(A_STAT, r); check("R8 edge wins over clear", r, 16'h0004);
    wr(A_STAT, 16'h0004);
    rd(A_STAT, r); check("R8 final clear", r, 16'h0000);

    summary();
    $finish;
  end

endmodule